// File: doc/BRIEF.md
# DDR ADC Receive Eye Trainer

This block sits behind the input buffers of a parallel ADC link that forwards its own clock and changes data on both clock edges. Every lane delivers one bit around the rising edge and one around the falling edge. The block captures both bits and packs them into one word per clock. At start-up it finds a good sampling delay for the external delay element before any sample is treated as valid.

Calibration works as follows. The block asks the converter for its alternating one/zero test pattern. Starting from a programmable tap, it first steps the delay tap upward and then downward. At every tap it lets the delay settle, then compares a run of captured words against the pattern. The first failing tap in each direction marks an edge of the eye, and the end of the tap range counts as an edge when no failure is found. The tap is then parked halfway between the two edges. The receiver's setup and hold needs are not balanced, so a fixed mid-period phase is not trusted.

A recalibrate input restarts the whole sequence at any time.

Top module: `adc_eye_trainer`

## Requirements
- R1: While reset is held, tap_o is 0 and locked_o, err_o, pattern_en_o and valid_o are all 0.
- R2: pattern_en_o is 1 throughout calibration (both sweeps) and 0 once the result is reached (locked or error).
- R3: The upward sweep begins at the start tap (start_tap_i, sampled when calibration begins). Its edge is the first tap at or above the start that fails, or 31 if taps up to 31 all pass.
- R4: The downward sweep begins again at the start tap. Its edge is the first tap at or below the start that fails, or 0 if taps down to 0 all pass.
- R5: When calibration ends, tap_o equals floor((upper + lower) / 2) and then holds steady until recalibration.
- R6: If upper minus lower is less than 4, err_o rises and locked_o stays 0. Otherwise locked_o rises and err_o stays 0. The two are never high together.
- R7: sample_o bit 2i carries lane i's rising-edge bit and bit 2i+1 its falling-edge bit. The calibration pattern is rising bits 1 and falling bits 0 (word 0x55 for four lanes). valid_o is high only while locked_o is high.
- R8: One clock with recal_i high drops locked_o, err_o and pattern_en_o on the next cycle, and the full sequence restarts, including when a calibration is already under way.
- R9: After each tap change, the first 16 words are ignored. A single mismatching word among the following 64 marks the tap as failing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Forwarded ADC clock; data is captured on both of its edges |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| recal_i | input | 1 | Restart calibration from the start-up state |
| start_tap_i | input | 5 | Tap at which both sweeps begin |
| dq_i | input | 4 | DDR data lanes |
| tap_o | output | 5 | Delay-tap setting for the external delay element |
| pattern_en_o | output | 1 | Requests the converter's alternating test pattern |
| locked_o | output | 1 | Calibration finished with an adequate eye |
| err_o | output | 1 | Calibration finished with an eye narrower than the minimum |
| sample_o | output | 8 | Packed word: rising/falling bit pairs per lane |
| valid_o | output | 1 | sample_o carries real samples |

## Verification
The bench models the delay element as a passing tap window. Inside the window it returns the clean pattern; outside it returns the inverted pattern. It also corrupts the first few words after every tap change, which separates correct settle handling from early checking.

Windows are tried centred, touching tap 0, touching tap 31, exactly at the minimum width, one tap narrower, and not containing the start tap, so that each edge rule and the width test are exercised on their own. One run injects a single bad word inside a passing window, which shows whether one mismatch is enough to fail a tap. Packing is checked over all 256 rising/falling data combinations after lock. Recalibration is tested both after a lock and in the middle of a sweep.

// File: rtl/eyetrn_pkg.sv
`timescale 1ns/1ps
package eyetrn_pkg;
  typedef enum logic [2:0] {ST_BOOT, ST_UP, ST_DOWN, ST_LOCK, ST_FAIL} cal_state_t;
  typedef enum logic [1:0] {WT_IDLE, WT_SETTLE, WT_CHECK} win_phase_t;
endpackage

// File: rtl/eyetrn_ddr_merge.sv
`timescale 1ns/1ps
// Two-edge capture, then one packed word per clock on the rising edge.
module eyetrn_ddr_merge #(
  parameter int LANES = 4,
  localparam int W = 2 * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] dq_i,
  output logic [W-1:0]     word_o
);
  logic [LANES-1:0] rise_q, fall_q;
  logic [W-1:0]     word_d, word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_q <= '0;
    else        rise_q <= dq_i;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= '0;
    else        fall_q <= dq_i;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_pack
    assign word_d[2*g]   = rise_q[g];
    assign word_d[2*g+1] = fall_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word_o = word_q;
endmodule

// File: rtl/eyetrn_window_test.sv
`timescale 1ns/1ps
// One tap trial: settle, then compare a run of words against the pattern.
module eyetrn_window_test
  import eyetrn_pkg::*;
#(
  parameter int W = 8,
  parameter logic [W-1:0] PATTERN = '0,
  parameter int SETTLE = 16,
  parameter int CHECK = 64,
  localparam int CMAX = (SETTLE > CHECK) ? SETTLE : CHECK,
  localparam int CNT_W = $clog2(CMAX + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         abort_i,
  input  logic         go_i,
  input  logic [W-1:0] word_i,
  output logic         done_o,
  output logic         fail_o
);
  win_phase_t       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             bad_q, bad_d, done_q, done_d, fail_q, fail_d;
  logic             miss;

  assign miss = (word_i != PATTERN);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    bad_d   = bad_q;
    done_d  = 1'b0;
    fail_d  = fail_q;
    if (abort_i) begin
      phase_d = WT_IDLE;
      cnt_d   = '0;
      bad_d   = 1'b0;
    end else begin
      case (phase_q)
        WT_IDLE: if (go_i) begin
          phase_d = WT_SETTLE;
          cnt_d   = '0;
          bad_d   = 1'b0;
        end
        WT_SETTLE: begin
          if (cnt_q == CNT_W'(SETTLE - 1)) begin
            phase_d = WT_CHECK;
            cnt_d   = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
        WT_CHECK: begin
          bad_d = bad_q | miss;
          if (cnt_q == CNT_W'(CHECK - 1)) begin
            done_d  = 1'b1;
            fail_d  = bad_q | miss;
            phase_d = WT_IDLE;
            cnt_d   = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
        default: phase_d = WT_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= WT_IDLE;
      cnt_q   <= '0;
      bad_q   <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      bad_q   <= bad_d;
      done_q  <= done_d;
      fail_q  <= fail_d;
    end
  end

  assign done_o = done_q;
  assign fail_o = fail_q;

  // R9: a mismatch seen while checking is remembered
  a_r9_miss_marks_tap: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == WT_CHECK && miss && !abort_i) |=> bad_q);
  // R9: a verdict only ever follows the checking phase
  a_r9_done_after_check: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(phase_q) == WT_CHECK);
endmodule

// File: rtl/adc_eye_trainer.sv
`timescale 1ns/1ps
module adc_eye_trainer
  import eyetrn_pkg::*;
#(
  parameter int LANES = 4,
  parameter int TAP_W = 5,
  parameter int SETTLE = 16,
  parameter int CHECK = 64,
  parameter int MIN_WIN = 4,
  localparam int W = 2 * LANES,
  localparam logic [TAP_W-1:0] TAP_MAX = {TAP_W{1'b1}},
  localparam logic [W-1:0] CAL_WORD = {LANES{2'b01}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             recal_i,
  input  logic [TAP_W-1:0] start_tap_i,
  input  logic [LANES-1:0] dq_i,
  output logic [TAP_W-1:0] tap_o,
  output logic             pattern_en_o,
  output logic             locked_o,
  output logic             err_o,
  output logic [W-1:0]     sample_o,
  output logic             valid_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [W-1:0] word;
  logic         go_q, go_d, trial_done, trial_fail;

  eyetrn_ddr_merge #(.LANES(LANES)) u_merge (
    .clk(clk), .rst_n(rst_n_s), .dq_i(dq_i), .word_o(word));

  eyetrn_window_test #(.W(W), .PATTERN(CAL_WORD), .SETTLE(SETTLE), .CHECK(CHECK)) u_trial (
    .clk(clk), .rst_n(rst_n_s), .abort_i(recal_i), .go_i(go_q),
    .word_i(word), .done_o(trial_done), .fail_o(trial_fail));

  cal_state_t       state_q, state_d;
  logic [TAP_W-1:0] tap_q, tap_d, hi_q, hi_d, start_q, start_d;
  logic [TAP_W:0]   span, mid_sum;

  assign span    = {1'b0, hi_q} - {1'b0, tap_q};
  assign mid_sum = {1'b0, hi_q} + {1'b0, tap_q};

  always_comb begin
    state_d = state_q;
    tap_d   = tap_q;
    hi_d    = hi_q;
    start_d = start_q;
    go_d    = 1'b0;
    if (recal_i) begin
      state_d = ST_BOOT;
    end else begin
      case (state_q)
        ST_BOOT: begin
          start_d = start_tap_i;
          tap_d   = start_tap_i;
          go_d    = 1'b1;
          state_d = ST_UP;
        end
        ST_UP: if (trial_done) begin
          go_d = 1'b1;
          if (trial_fail || tap_q == TAP_MAX) begin
            hi_d    = tap_q;
            tap_d   = start_q;
            state_d = ST_DOWN;
          end else tap_d = tap_q + 1'b1;
        end
        ST_DOWN: if (trial_done) begin
          if (trial_fail || tap_q == '0) begin
            tap_d   = mid_sum[TAP_W:1];
            state_d = (span < (TAP_W+1)'(MIN_WIN)) ? ST_FAIL : ST_LOCK;
          end else begin
            tap_d = tap_q - 1'b1;
            go_d  = 1'b1;
          end
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_BOOT;
      tap_q   <= '0;
      hi_q    <= '0;
      start_q <= '0;
      go_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      tap_q   <= tap_d;
      hi_q    <= hi_d;
      start_q <= start_d;
      go_q    <= go_d;
    end
  end

  assign tap_o        = tap_q;
  assign pattern_en_o = (state_q == ST_UP) || (state_q == ST_DOWN);
  assign locked_o     = (state_q == ST_LOCK);
  assign err_o        = (state_q == ST_FAIL);
  assign sample_o     = word;
  assign valid_o      = locked_o;

  // R6: never both outcomes at once
  a_r6_outcome_exclusive: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(locked_o && err_o));
  // R7: samples only marked valid when locked
  a_r7_valid_needs_lock: assert property (@(posedge clk) disable iff (!rst_n_s)
    valid_o |-> locked_o);
  // R2: test pattern released once locked
  a_r2_pattern_off_locked: assert property (@(posedge clk) disable iff (!rst_n_s)
    locked_o |-> !pattern_en_o);
  // R5: tap holds while locked
  a_r5_tap_holds: assert property (@(posedge clk) disable iff (!rst_n_s)
    (locked_o && !recal_i) |=> $stable(tap_o));
  // R8: recalibration drops the outcome at once
  a_r8_recal_restarts: assert property (@(posedge clk) disable iff (!rst_n_s)
    recal_i |=> (!locked_o && !err_o && !pattern_en_o));
endmodule

// File: tb/adc_eye_trainer_bench.sv
`timescale 1ns/1ps
module adc_eye_trainer_bench;
  localparam int LANES = 4;
  localparam int W = 2 * LANES;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n, recal;
  logic [4:0]       start_tap;
  logic [LANES-1:0] dq;
  logic [4:0]       tap_o;
  logic             pattern_en_o, locked_o, err_o, valid_o;
  logic [W-1:0]     sample_o;

  adc_eye_trainer u_adc_eye_trainer (
    .clk(clk), .rst_n(rst_n), .recal_i(recal), .start_tap_i(start_tap), .dq_i(dq),
    .tap_o(tap_o), .pattern_en_o(pattern_en_o), .locked_o(locked_o), .err_o(err_o),
    .sample_o(sample_o), .valid_o(valid_o));

  int errors = 0, checks = 0;
  int wl = 8, wh = 23, gt = -1;
  int age = 0;
  logic [4:0] prev_tap = '0;
  logic [LANES-1:0] d_rise = '0, d_fall = '0;

  // delay-element model: age since last tap change
  always @(negedge clk) begin
    if (tap_o != prev_tap) age = 0;
    else if (age < 100000) age = age + 1;
    prev_tap = tap_o;
  end

  function automatic bit corrupt_now();
    int t = int'(tap_o);
    return (t < wl) || (t > wh) || (age < 8) || (t == gt && age == 40);
  endfunction

  initial begin
    dq = '0;
    forever begin
      @(posedge clk); #1.25;
      dq = pattern_en_o ? (corrupt_now() ? '1 : '0) : d_fall;
    end
  end
  initial begin
    forever begin
      @(negedge clk); #1.25;
      dq = pattern_en_o ? (corrupt_now() ? '0 : '1) : d_rise;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit pass_t(int t);
    return (t >= wl) && (t <= wh) && (t != gt);
  endfunction

  task automatic run_cal(int nwl, int nwh, int ns, int ngt, bit use_recal);
    int hi, lo, n, t;
    bit pat_ok, val_ok, ex_err;
    logic [4:0] tap_seen;
    wl = nwl; wh = nwh; gt = ngt; start_tap = 5'(ns);
    if (use_recal) begin
      @(negedge clk); recal = 1'b1;
      @(negedge clk); recal = 1'b0;
      check(!locked_o && !err_o && !pattern_en_o, "R8 restart", int'({locked_o, err_o, pattern_en_o}), 0);
    end
    pat_ok = 1'b1; val_ok = 1'b1; n = 0;
    while (!(locked_o || err_o) && n < 8000) begin
      @(negedge clk); n++;
      if (n > 2 && !pattern_en_o && !(locked_o || err_o)) pat_ok = 1'b0;
      if (valid_o && !locked_o) val_ok = 1'b0;
    end
    check(n < 8000, "R5 calibration ends", n, 8000);
    check(pat_ok, "R2 pattern held during sweep", 0, 1);
    check(val_ok, "R7 no valid during sweep", 0, 1);
    t = ns; while (pass_t(t) && t != 31) t++; hi = t;   // R3
    t = ns; while (pass_t(t) && t != 0)  t--; lo = t;   // R4
    ex_err = (hi - lo) < 4;
    check(int'(tap_o) == (hi + lo) / 2, "R3 R4 R5 centred tap", int'(tap_o), (hi + lo) / 2);
    check(err_o == ex_err, "R6 error flag", int'(err_o), int'(ex_err));
    check(locked_o == !ex_err, "R6 locked flag", int'(locked_o), int'(!ex_err));
    check(!pattern_en_o, "R2 pattern released", int'(pattern_en_o), 0);
    tap_seen = tap_o;
    repeat (20) @(negedge clk);
    check(tap_o == tap_seen, "R5 tap holds", int'(tap_o), int'(tap_seen));
    check(valid_o == locked_o, "R7 valid follows lock", int'(valid_o), int'(locked_o));
  endtask

  initial begin
    #(200000 * 5.0);
    errors++; checks++;
    $display("FAIL R5 watchdog actual=expired expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] exp_w;
    rst_n = 1'b0; recal = 1'b0; start_tap = 5'd16;
    repeat (4) @(negedge clk);
    check(tap_o == 0 && !locked_o && !err_o && !pattern_en_o && !valid_o, "R1 reset state",
          int'({tap_o, locked_o, err_o, pattern_en_o, valid_o}), 0);
    rst_n = 1'b1;
    run_cal(8, 23, 16, -1, 1'b0);   // centred
    for (int r = 0; r < 16; r++) begin   // R7 packing, all combinations
      for (int f = 0; f < 16; f++) begin
        d_rise = 4'(r); d_fall = 4'(f);
        repeat (3) @(negedge clk);
        for (int i = 0; i < LANES; i++) begin
          exp_w[2*i]   = d_rise[i];
          exp_w[2*i+1] = d_fall[i];
        end
        check(sample_o == exp_w && valid_o, "R7 packing", int'(sample_o), int'(exp_w));
      end
    end
    run_cal(0, 31, 10, -1, 1'b1);   // R3 R4 both ends of range
    run_cal(20, 31, 25, -1, 1'b1);  // R3 top end
    run_cal(0, 6, 3, -1, 1'b1);     // R4 bottom end
    run_cal(10, 11, 10, -1, 1'b1);  // R6 one below minimum
    run_cal(10, 12, 11, -1, 1'b1);  // R6 exactly minimum
    run_cal(5, 15, 20, -1, 1'b1);   // start outside window
    run_cal(5, 20, 10, 14, 1'b1);   // R9 single bad word fails tap
    for (int s = 8; s <= 23; s += 5) run_cal(8, 23, s, -1, 1'b1);
    // R8 recal in mid-sweep
    wl = 2; wh = 29; start_tap = 5'd15;
    @(negedge clk); recal = 1'b1; @(negedge clk); recal = 1'b0;
    repeat (300) @(negedge clk);
    check(pattern_en_o, "R8 sweep under way", int'(pattern_en_o), 1);
    run_cal(12, 27, 18, -1, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule